// File: doc/BRIEF.md
# Single-channel SCSI host DMA channel

This block is the bus-master DMA channel of a SCSI host adapter. Software programs a byte count, a memory address and a descriptor-list address into three starting registers, then issues a start command. Start copies the starting values into working copies, clears the status flags and enables the channel. From then on the SCSI core asks for transfers, giving a direction and a byte length. The channel grants the smaller of that length and the bytes still owed, presents the current working address, and advances its working count and address by the granted amount.

Eight 32-bit registers sit behind a word-indexed access port. The status register holds a done flag. It is set when the working count reaches zero or when the SCSI core signals command completion. It also reflects the core's interrupt line live. An external mode bit selects how the error, abort and done flags clear: by writing ones to them, or by reading the status register.

Top module: `sdma_chan_top`

## Requirements
- R1: After reset the command register reads 0, the working count reads 0, the working address reads 0xFFFFFFFF, the working list address reads 0xFFFFFFFD, the status reads 0 (core interrupt low), and `xfer_req_ready` is low.
- R2: Register index 0 is command, 1 starting count, 2 starting address, 3 working count, 4 working address, 5 status, 6 starting list address, 7 working list address. Indexes 0, 1, 2 and 6 are writable and read back as written. Writes to indexes 3, 4 and 7 are dropped.
- R3: A command write with bits [1:0] = 3 (start) copies starting count, address and list address into their working copies, clears status bits 0 to 5 and raises `xfer_req_ready`.
- R4: Command code 0 (idle) drops `xfer_req_ready` and no further grant is given. Code 1 changes nothing. Code 2 (abort) raises `abort_req` for exactly the cycle of the write.
- R5: Command bit 7 gives the accepted direction (1 = device to memory, matching `xfer_req_to_mem` = 1). A request in the other direction gets `xfer_gnt_ok` low and leaves count, address and status unchanged.
- R6: An accepted request has `xfer_gnt_len` = min(requested length, working count) and `xfer_gnt_addr` = working address. After the clock, the working count is lower by the grant and the working address is higher by the grant, modulo 2^32.
- R7: Status bit 3 (done) is set when an accepted transfer leaves the working count at zero, including a zero-length grant on an empty count.
- R8: Status bit 4 on a read always equals the live `core_irq` input.
- R9: With `sts_w1c_mode` high, a status write clears each of bits 1, 2 and 3 that is written as one, and status reads do not clear them.
- R10: With `sts_w1c_mode` low, status writes have no effect, and a status read returns bits 1 to 3 and then clears them.
- R11: A `cmd_done` pulse forces the working count to zero and sets done.
- R12: In one cycle, `cmd_done` takes precedence over an accepted transfer (count becomes zero, address unchanged), and setting done takes precedence over clearing it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_idx | input | 3 | Register word index for writes |
| reg_wr_data | input | 32 | Write data |
| reg_rd_en | input | 1 | Register read strobe (side effect on status) |
| reg_rd_idx | input | 3 | Register word index for reads |
| reg_rd_data | output | 32 | Read data, combinational from the index |
| sts_w1c_mode | input | 1 | 1: status flags clear by writing ones; 0: clear on read |
| core_irq | input | 1 | Live interrupt state of the SCSI core |
| cmd_done | input | 1 | Command-complete pulse from the SCSI core |
| xfer_req_valid | input | 1 | Transfer request from the SCSI core |
| xfer_req_to_mem | input | 1 | Request direction, 1 = device to memory |
| xfer_req_len | input | 32 | Requested byte length |
| xfer_req_ready | output | 1 | Channel enabled, request is taken this cycle |
| xfer_gnt_ok | output | 1 | Request accepted (valid, ready, direction matches) |
| xfer_gnt_len | output | 32 | Granted byte length |
| xfer_gnt_addr | output | 32 | Memory address for the transfer |
| abort_req | output | 1 | One-cycle request to cancel the current SCSI request |

## Verification
The hardest states to reach from the ports are the collisions: a command-complete pulse that lands in the same cycle as an accepted transfer, and a done-setting transfer that lands in the same cycle as a write-one-to-clear of done. The bench drives these inputs together within a single low clock phase, so that both events meet one edge. It then reads count, address and status back through the register port. The clear-on-read behaviour is shown by reading status twice in a row: the first read returns the flag and the second read finds it gone.

// File: rtl/sdma_pkg.sv
package sdma_pkg;

  localparam int WORD_W = 32;
  localparam int IDX_W  = 3;
  localparam int STAT_W = 6;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [IDX_W-1:0] {
    IX_CMD   = 3'd0,
    IX_SCNT  = 3'd1,
    IX_SADDR = 3'd2,
    IX_WCNT  = 3'd3,
    IX_WADDR = 3'd4,
    IX_STAT  = 3'd5,
    IX_SLIST = 3'd6,
    IX_WLIST = 3'd7
  } reg_idx_e;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_BLAST = 2'd1,
    OP_ABORT = 2'd2,
    OP_START = 2'd3
  } cmd_op_e;

  localparam int CMD_DIR_BIT = 7;
  localparam int ST_DONE_BIT = 3;
  localparam int ST_IRQ_BIT  = 4;

  localparam logic [STAT_W-1:0] ST_CLR_MASK = 6'b001110;

  localparam word_t WADDR_RST = 32'hFFFF_FFFF;
  localparam word_t WLIST_RST = 32'hFFFF_FFFD;

  // Length actually granted: never more than is still owed.
  function automatic word_t clip_len(word_t req, word_t owed);
    return (req < owed) ? req : owed;
  endfunction

  // Stored status after the two clear sources are applied.
  function automatic logic [STAT_W-1:0] stat_after_clear(
    logic [STAT_W-1:0] cur, logic w1c, logic wr_hit,
    logic [STAT_W-1:0] wr_bits, logic rd_hit);
    logic [STAT_W-1:0] v;
    v = cur;
    if (w1c && wr_hit)  v = v & ~(wr_bits & ST_CLR_MASK);
    if (!w1c && rd_hit) v = v & ~ST_CLR_MASK;
    return v;
  endfunction

endpackage

// File: rtl/sdma_cmd_regs.sv
module sdma_cmd_regs
  import sdma_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  word_t            wr_data,
  output word_t            cmd_q,
  output word_t            scnt_q,
  output word_t            saddr_q,
  output word_t            slist_q,
  output logic             start_p,
  output logic             abort_p,
  output logic             dma_en,
  output logic             to_mem
);

  logic    cmd_wr;
  cmd_op_e op;

  assign cmd_wr  = wr_en && (wr_idx == IX_CMD);
  assign op      = cmd_op_e'(wr_data[1:0]);
  assign start_p = cmd_wr && (op == OP_START);
  assign abort_p = cmd_wr && (op == OP_ABORT);
  assign to_mem  = cmd_q[CMD_DIR_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      scnt_q  <= '0;
      saddr_q <= '0;
      slist_q <= '0;
      dma_en  <= 1'b0;
    end else if (wr_en) begin
      unique case (wr_idx)
        IX_CMD: begin
          cmd_q <= wr_data;
          if (op == OP_IDLE)  dma_en <= 1'b0;
          if (op == OP_START) dma_en <= 1'b1;
        end
        IX_SCNT:  scnt_q  <= wr_data;
        IX_SADDR: saddr_q <= wr_data;
        IX_SLIST: slist_q <= wr_data;
        default: ;
      endcase
    end
  end

  // R4
  idle_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && op == OP_IDLE) |=> !dma_en);

  // R3
  start_enables_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_p |=> dma_en);

endmodule

// File: rtl/sdma_work_ctr.sv
module sdma_work_ctr
  import sdma_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start_p,
  input  word_t scnt,
  input  word_t saddr,
  input  word_t slist,
  input  logic  cmd_done,
  input  logic  fire,
  input  word_t req_len,
  output word_t wcnt_q,
  output word_t waddr_q,
  output word_t wlist_q,
  output word_t gnt_len,
  output logic  reach_zero
);

  word_t cnt_left;

  assign gnt_len    = clip_len(req_len, wcnt_q);
  assign cnt_left   = wcnt_q - gnt_len;
  assign reach_zero = !start_p && (cmd_done || (fire && cnt_left == '0));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wcnt_q  <= '0;
      waddr_q <= WADDR_RST;
      wlist_q <= WLIST_RST;
    end else if (start_p) begin
      wcnt_q  <= scnt;
      waddr_q <= saddr;
      wlist_q <= slist;
    end else if (cmd_done) begin
      wcnt_q  <= '0;
    end else if (fire) begin
      wcnt_q  <= cnt_left;
      waddr_q <= waddr_q + gnt_len;
    end
  end

  // R6
  gnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (gnt_len <= wcnt_q) && (gnt_len <= req_len));

  // R6
  advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !start_p && !cmd_done) |=>
      (wcnt_q == $past(wcnt_q) - $past(gnt_len)) &&
      (waddr_q == $past(waddr_q) + $past(gnt_len)));

  // R3
  snapshot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_p |=> (wcnt_q == $past(scnt)) && (waddr_q == $past(saddr)) &&
                (wlist_q == $past(slist)));

  // R11
  done_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_done && !start_p) |=> (wcnt_q == '0) && $stable(waddr_q));

endmodule

// File: rtl/sdma_status.sv
module sdma_status
  import sdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_p,
  input  logic              set_done,
  input  logic              wr_hit,
  input  logic [STAT_W-1:0] wr_bits,
  input  logic              rd_hit,
  input  logic              w1c_mode,
  input  logic              core_irq,
  output logic [STAT_W-1:0] stat_view
);

  logic [STAT_W-1:0] st_q;
  logic [STAT_W-1:0] st_cleared;

  assign st_cleared = stat_after_clear(st_q, w1c_mode, wr_hit, wr_bits, rd_hit);

  always_comb begin
    stat_view             = st_q;
    stat_view[ST_IRQ_BIT] = core_irq;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= '0;
    end else if (start_p) begin
      st_q <= '0;
    end else begin
      st_q             <= st_cleared;
      st_q[ST_IRQ_BIT] <= 1'b0;
      if (set_done) st_q[ST_DONE_BIT] <= 1'b1;
    end
  end

  // R7
  done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_done && !start_p) |=> st_q[ST_DONE_BIT]);

  // R10
  wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!w1c_mode && wr_hit && !rd_hit && !set_done && !start_p) |=> $stable(st_q));

  // R9
  rd_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (w1c_mode && rd_hit && !wr_hit && !start_p) |=> $stable(st_q));

endmodule

// File: rtl/sdma_chan_top.sv
module sdma_chan_top
  import sdma_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr_en,
  input  logic [2:0]  reg_wr_idx,
  input  logic [31:0] reg_wr_data,
  input  logic        reg_rd_en,
  input  logic [2:0]  reg_rd_idx,
  output logic [31:0] reg_rd_data,
  input  logic        sts_w1c_mode,
  input  logic        core_irq,
  input  logic        cmd_done,
  input  logic        xfer_req_valid,
  input  logic        xfer_req_to_mem,
  input  logic [31:0] xfer_req_len,
  output logic        xfer_req_ready,
  output logic        xfer_gnt_ok,
  output logic [31:0] xfer_gnt_len,
  output logic [31:0] xfer_gnt_addr,
  output logic        abort_req
);

  word_t             cmd_q, scnt_q, saddr_q, slist_q;
  word_t             wcnt_q, waddr_q, wlist_q, gnt_len;
  logic              start_p, abort_p, dma_en, to_mem;
  logic              fire, reach_zero, stat_wr, stat_rd;
  logic [STAT_W-1:0] stat_view;

  sdma_cmd_regs u_cmd (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr_en),
    .wr_idx  (reg_wr_idx),
    .wr_data (reg_wr_data),
    .cmd_q   (cmd_q),
    .scnt_q  (scnt_q),
    .saddr_q (saddr_q),
    .slist_q (slist_q),
    .start_p (start_p),
    .abort_p (abort_p),
    .dma_en  (dma_en),
    .to_mem  (to_mem)
  );

  assign fire = xfer_req_valid && dma_en && (xfer_req_to_mem == to_mem);

  sdma_work_ctr u_work (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_p    (start_p),
    .scnt       (scnt_q),
    .saddr      (saddr_q),
    .slist      (slist_q),
    .cmd_done   (cmd_done),
    .fire       (fire),
    .req_len    (xfer_req_len),
    .wcnt_q     (wcnt_q),
    .waddr_q    (waddr_q),
    .wlist_q    (wlist_q),
    .gnt_len    (gnt_len),
    .reach_zero (reach_zero)
  );

  assign stat_wr = reg_wr_en && (reg_wr_idx == IX_STAT);
  assign stat_rd = reg_rd_en && (reg_rd_idx == IX_STAT);

  sdma_status u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_p   (start_p),
    .set_done  (reach_zero),
    .wr_hit    (stat_wr),
    .wr_bits   (reg_wr_data[STAT_W-1:0]),
    .rd_hit    (stat_rd),
    .w1c_mode  (sts_w1c_mode),
    .core_irq  (core_irq),
    .stat_view (stat_view)
  );

  always_comb begin
    unique case (reg_rd_idx)
      IX_CMD:   reg_rd_data = cmd_q;
      IX_SCNT:  reg_rd_data = scnt_q;
      IX_SADDR: reg_rd_data = saddr_q;
      IX_WCNT:  reg_rd_data = wcnt_q;
      IX_WADDR: reg_rd_data = waddr_q;
      IX_STAT:  reg_rd_data = {{(WORD_W-STAT_W){1'b0}}, stat_view};
      IX_SLIST: reg_rd_data = slist_q;
      default:  reg_rd_data = wlist_q;
    endcase
  end

  assign xfer_req_ready = dma_en;
  assign xfer_gnt_ok    = fire;
  assign xfer_gnt_len   = gnt_len;
  assign xfer_gnt_addr  = waddr_q;
  assign abort_req      = abort_p;

  // R5
  wrong_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req_valid && dma_en && (xfer_req_to_mem != to_mem) &&
     !start_p && !cmd_done) |=> $stable(wcnt_q) && $stable(waddr_q));

  // R4
  abort_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |-> reg_wr_en && (reg_wr_idx == IX_CMD));

endmodule

// File: tb/sdma_chan_top_tb.sv
`timescale 1ns/1ps
module sdma_chan_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [2:0]  reg_wr_idx = '0;
  logic [31:0] reg_wr_data = '0;
  logic        reg_rd_en = 1'b0;
  logic [2:0]  reg_rd_idx = '0;
  logic [31:0] reg_rd_data;
  logic        sts_w1c_mode = 1'b0;
  logic        core_irq = 1'b0;
  logic        cmd_done = 1'b0;
  logic        xfer_req_valid = 1'b0;
  logic        xfer_req_to_mem = 1'b0;
  logic [31:0] xfer_req_len = '0;
  logic        xfer_req_ready, xfer_gnt_ok, abort_req;
  logic [31:0] xfer_gnt_len, xfer_gnt_addr;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  sdma_chan_top dut_i (.*);

  typedef struct packed {
    logic [31:0] scnt;
    logic [31:0] saddr;
    logic        cmd_to_mem;
    logic        req_to_mem;
    logic [31:0] req_len;
    logic        exp_ok;
    logic [31:0] exp_gnt;
    logic [31:0] exp_wcnt;
    logic [31:0] exp_waddr;
    logic        exp_done;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{32'd100, 32'h1000, 1'b0, 1'b0, 32'd40, 1'b1, 32'd40, 32'd60, 32'h1028, 1'b0},
    '{32'd16, 32'h2000, 1'b1, 1'b1, 32'd64, 1'b1, 32'd16, 32'd0, 32'h2010, 1'b1},
    '{32'd50, 32'h300, 1'b1, 1'b0, 32'd10, 1'b0, 32'd10, 32'd50, 32'h300, 1'b0},
    '{32'd0, 32'hABC, 1'b0, 1'b0, 32'd8, 1'b1, 32'd0, 32'd0, 32'hABC, 1'b1},
    '{32'd32, 32'hFFFF_FFF0, 1'b0, 1'b0, 32'd32, 1'b1, 32'd32, 32'd0, 32'h10, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_idx = idx; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] idx, output logic [31:0] d);
    @(negedge clk);
    reg_rd_en = 1'b1; reg_rd_idx = idx;
    #1 d = reg_rd_data;
    @(negedge clk);
    reg_rd_en = 1'b0;
  endtask

  task automatic xfer(input logic dir, input logic [31:0] len);
    @(negedge clk);
    xfer_req_valid = 1'b1; xfer_req_to_mem = dir; xfer_req_len = len;
    @(negedge clk);
    xfer_req_valid = 1'b0;
  endtask

  task automatic start(input logic [31:0] cnt, input logic [31:0] addr, input logic dir);
    wr(3'd1, cnt);
    wr(3'd2, addr);
    wr(3'd0, {24'd0, dir, 5'd0, 2'd3});
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    chk("R1 ready", {31'd0, xfer_req_ready}, 32'd0);
    rd(3'd0, d); chk("R1 cmd", d, 32'd0);
    rd(3'd3, d); chk("R1 wcnt", d, 32'd0);
    rd(3'd4, d); chk("R1 waddr", d, 32'hFFFF_FFFF);
    rd(3'd7, d); chk("R1 wlist", d, 32'hFFFF_FFFD);
    rd(3'd5, d); chk("R1 stat", d, 32'd0);

    // R2 writable vs dropped indexes
    wr(3'd1, 32'd77); wr(3'd2, 32'h4000); wr(3'd6, 32'hABCD);
    wr(3'd3, 32'h5555); wr(3'd4, 32'h6666); wr(3'd7, 32'h7777);
    rd(3'd1, d); chk("R2 scnt", d, 32'd77);
    rd(3'd2, d); chk("R2 saddr", d, 32'h4000);
    rd(3'd6, d); chk("R2 slist", d, 32'hABCD);
    rd(3'd3, d); chk("R2 wcnt dropped", d, 32'd0);
    rd(3'd4, d); chk("R2 waddr dropped", d, 32'hFFFF_FFFF);
    rd(3'd7, d); chk("R2 wlist dropped", d, 32'hFFFF_FFFD);

    // R3 start snapshot
    wr(3'd0, 32'h0000_0003);
    chk("R3 ready", {31'd0, xfer_req_ready}, 32'd1);
    rd(3'd7, d); chk("R3 wlist copy", d, 32'hABCD);
    rd(3'd3, d); chk("R3 wcnt copy", d, 32'd77);
    rd(3'd0, d); chk("R2 cmd readback", d, 32'h3);

    // Vector table: R5 R6 R7
    for (int i = 0; i < 5; i++) begin
      start(VECS[i].scnt, VECS[i].saddr, VECS[i].cmd_to_mem);
      @(negedge clk);
      xfer_req_valid = 1'b1; xfer_req_to_mem = VECS[i].req_to_mem;
      xfer_req_len = VECS[i].req_len;
      #1;
      chk("R5 gnt_ok", {31'd0, xfer_gnt_ok}, {31'd0, VECS[i].exp_ok});
      if (VECS[i].exp_ok) begin
        chk("R6 gnt_len", xfer_gnt_len, VECS[i].exp_gnt);
        chk("R6 gnt_addr", xfer_gnt_addr, VECS[i].saddr);
      end
      @(negedge clk);
      xfer_req_valid = 1'b0;
      rd(3'd3, d); chk("R6 wcnt", d, VECS[i].exp_wcnt);
      rd(3'd4, d); chk("R6 waddr", d, VECS[i].exp_waddr);
      rd(3'd5, d); chk("R7 done", {31'd0, d[3]}, {31'd0, VECS[i].exp_done});
    end

    // R3 start clears status
    start(32'd4, 32'h100, 1'b0);
    xfer(1'b0, 32'd4);
    start(32'd8, 32'h100, 1'b0);
    rd(3'd5, d); chk("R3 stat cleared", d, 32'd0);

    // R4 blast, abort, idle
    wr(3'd0, 32'h1);
    chk("R4 blast ready", {31'd0, xfer_req_ready}, 32'd1);
    rd(3'd3, d); chk("R4 blast wcnt", d, 32'd8);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_idx = 3'd0; reg_wr_data = 32'h2;
    #1 chk("R4 abort pulse", {31'd0, abort_req}, 32'd1);
    @(negedge clk);
    reg_wr_en = 1'b0;
    #1 chk("R4 abort ends", {31'd0, abort_req}, 32'd0);
    wr(3'd0, 32'h0);
    chk("R4 idle ready", {31'd0, xfer_req_ready}, 32'd0);
    @(negedge clk);
    xfer_req_valid = 1'b1; xfer_req_to_mem = 1'b0; xfer_req_len = 32'd2;
    #1 chk("R4 idle no grant", {31'd0, xfer_gnt_ok}, 32'd0);
    @(negedge clk);
    xfer_req_valid = 1'b0;
    rd(3'd3, d); chk("R4 idle wcnt", d, 32'd8);

    // R8 live interrupt
    core_irq = 1'b1;
    rd(3'd5, d); chk("R8 irq high", {31'd0, d[4]}, 32'd1);
    core_irq = 1'b0;
    rd(3'd5, d); chk("R8 irq low", {31'd0, d[4]}, 32'd0);

    // R9 write-one-to-clear mode
    sts_w1c_mode = 1'b1;
    start(32'd4, 32'h200, 1'b0);
    xfer(1'b0, 32'd4);
    rd(3'd5, d); chk("R9 done first read", {31'd0, d[3]}, 32'd1);
    rd(3'd5, d); chk("R9 read keeps", {31'd0, d[3]}, 32'd1);
    wr(3'd5, 32'h0);
    rd(3'd5, d); chk("R9 zero write keeps", {31'd0, d[3]}, 32'd1);
    wr(3'd5, 32'h8);
    rd(3'd5, d); chk("R9 one write clears", {31'd0, d[3]}, 32'd0);

    // R10 clear-on-read mode
    sts_w1c_mode = 1'b0;
    start(32'd4, 32'h200, 1'b0);
    xfer(1'b0, 32'd4);
    wr(3'd5, 32'h8);
    rd(3'd5, d); chk("R10 write ignored", {31'd0, d[3]}, 32'd1);
    rd(3'd5, d); chk("R10 read cleared", {31'd0, d[3]}, 32'd0);

    // R11 command complete
    start(32'd100, 32'h900, 1'b0);
    @(negedge clk); cmd_done = 1'b1;
    @(negedge clk); cmd_done = 1'b0;
    rd(3'd3, d); chk("R11 wcnt zero", d, 32'd0);
    rd(3'd5, d); chk("R11 done", {31'd0, d[3]}, 32'd1);

    // R12 cmd_done beats transfer
    start(32'd100, 32'hA00, 1'b0);
    @(negedge clk);
    cmd_done = 1'b1; xfer_req_valid = 1'b1; xfer_req_to_mem = 1'b0; xfer_req_len = 32'd10;
    @(negedge clk);
    cmd_done = 1'b0; xfer_req_valid = 1'b0;
    rd(3'd3, d); chk("R12 wcnt", d, 32'd0);
    rd(3'd4, d); chk("R12 waddr held", d, 32'hA00);

    // R12 done set beats write-one clear
    sts_w1c_mode = 1'b1;
    start(32'd4, 32'hB00, 1'b0);
    @(negedge clk);
    xfer_req_valid = 1'b1; xfer_req_to_mem = 1'b0; xfer_req_len = 32'd4;
    reg_wr_en = 1'b1; reg_wr_idx = 3'd5; reg_wr_data = 32'h8;
    @(negedge clk);
    xfer_req_valid = 1'b0; reg_wr_en = 1'b0;
    rd(3'd5, d); chk("R12 set wins", {31'd0, d[3]}, 32'd1);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule